// File: doc/BRIEF.md
# SPI Register-Access Target with In-Band Wait States

This block is an SPI target (mode 0, most significant bit first) that lets an external host read and write an internal register space. The host opens every transaction with a four-byte header. The first byte gives the direction and the transfer length. The next three bytes give a 24-bit register address, high byte first. Once the header is in, the block raises a one-cycle request toward a register backend. It then holds the host in a wait loop: it returns 0x00 for every byte the host clocks while the backend's ready flag, brought through a synchroniser, stays low. When the flag is high it returns a single 0x01 byte, and the data bytes follow immediately after it.

For reads, each data byte comes from the backend at the current address, which advances by one per byte. For writes, each received data byte is handed to the backend as an address/data/valid pulse. After a complete transaction, releasing chip-select makes the block pull an active-low interrupt line low for a set number of system clocks. This tells the host that the block can take the next transaction. A chip-select assertion that carries no clock edges is treated as a wake event. It raises a single-cycle wake pulse and produces no request and no interrupt.

All SPI pins are oversampled in the system clock domain. The SPI clock must therefore be several times slower than the system clock.

Top module: `spi_regtarget`

## Requirements
- R1: After the fourth header byte, `bk_req` pulses for one cycle with `bk_read` equal to bit 7 of header byte 0 (1 = read, 0 = write), `bk_len_m1` equal to bits 5:0 of byte 0 (length minus one, 1 to 64 bytes), and `bk_addr` equal to header bytes 1..3 taken as a 24-bit value, most significant byte first.
- R2: MISO carries 0x00 during all four header bytes.
- R3: After the header, each byte that the host clocks while the synchronised ready flag is low returns 0x00, so any number of wait bytes, including zero and three, is delivered.
- R4: The first byte decided while ready is high returns exactly 0x01, and the first data byte is the very next byte.
- R5: In a read, data byte i returns `bk_rdata` presented for `bk_addr` = base + i, most significant bit first. Bits are driven after the SCLK falling edge and are valid at the rising edge.
- R6: In a write, data byte i produces one `bk_wr_valid` pulse with `bk_wdata` equal to the byte and `bk_addr` = base + i.
- R7: Bytes clocked after the last data byte return 0x00 and produce no write pulse.
- R8: Releasing chip-select after a transaction whose data phase has completed drives `irq_n` low for exactly IRQ_CYCLES system clocks.
- R9: Releasing chip-select before the data phase completes produces no interrupt pulse.
- R10: A chip-select assertion and release with no SCLK rising edge produces one `wake_pulse` cycle, no `bk_req` and no interrupt.
- R11: Out of reset, `irq_n` is high, and `spi_miso`, `bk_req`, `bk_wr_valid` and `wake_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip-select from the host |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| bk_ready | input | 1 | Backend ready flag, synchronised inside |
| bk_rdata | input | 8 | Backend read byte for the address on `bk_addr` |
| bk_req | output | 1 | One-cycle request after the header |
| bk_read | output | 1 | Direction of the current transaction (1 = read) |
| bk_addr | output | ADDR_W | Current byte address (write address during `bk_wr_valid`) |
| bk_len_m1 | output | LEN_W | Transfer length minus one |
| bk_wr_valid | output | 1 | One-cycle strobe for a received write byte |
| bk_wdata | output | 8 | Write byte |
| wake_pulse | output | 1 | One-cycle pulse on a clockless chip-select toggle |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
The bench builds the block with IRQ_CYCLES = 5 and SYNC_STAGES = 2, and keeps the 24-bit address and the 6-bit length field. This keeps the interrupt window short enough to count exactly after every transaction. The bench sweeps both directions, wait counts 0 to 3 and lengths 1, 2, 5 and 8. The eight-byte case starts at low address byte 0xFC, so the address increment carries into the middle byte. Separate cases cover the four-byte read of 0xD40F00 that returns 0xE01A2800 after three wait bytes, a transaction aborted in its data phase, and a clockless chip-select toggle.

// File: rtl/spi_regtarget_pkg.sv
`timescale 1ns/1ps
package spi_regtarget_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] WAIT_CODE = 8'h00;
  localparam logic [BYTE_W-1:0] GO_CODE   = 8'h01;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_WAIT,
    ST_FLAG,
    ST_DATA,
    ST_DONE
  } xfer_state_t;
endpackage

// File: rtl/spi_regtarget_sync.sv
`timescale 1ns/1ps
module spi_regtarget_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_regtarget_shift.sv
`timescale 1ns/1ps
module spi_regtarget_shift
  import spi_regtarget_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] tx_next,
  output logic              miso,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d, rxb_q, rxb_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              done_q, done_d;

  always_comb begin
    rx_d   = rx_q;
    tx_d   = tx_q;
    rxb_d  = rxb_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    if (!cs_act) begin
      bit_d = '0;
      tx_d  = '0;
    end else if (sclk_rise) begin
      rx_d  = {rx_q[BYTE_W-2:0], mosi};
      bit_d = bit_q + 1'b1;
      if (bit_q == BIT_W'(BYTE_W-1)) begin
        done_d = 1'b1;
        rxb_d  = {rx_q[BYTE_W-2:0], mosi};
      end
    end else if (sclk_fall) begin
      // at a byte boundary the next byte is loaded, otherwise shift
      tx_d = (bit_q == '0) ? tx_next : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      rxb_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      rxb_q  <= rxb_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  assign miso      = tx_q[BYTE_W-1];
  assign byte_done = done_q;
  assign rx_byte   = rxb_q;

  assert_byte_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sclk_rise));
  assert_idle_miso_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_act) |-> !miso);
endmodule

// File: rtl/spi_regtarget_ctrl.sv
`timescale 1ns/1ps
module spi_regtarget_ctrl
  import spi_regtarget_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W = 6,
  parameter int IRQ_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              sclk_rise,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rdy,
  input  logic [BYTE_W-1:0] bk_rdata,
  output logic [BYTE_W-1:0] tx_next,
  output logic              bk_req,
  output logic              bk_read,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [LEN_W-1:0]  bk_len_m1,
  output logic              bk_wr_valid,
  output logic [BYTE_W-1:0] bk_wdata,
  output logic              wake_pulse,
  output logic              irq_n
);
  localparam int HDR_BYTES = 1 + ADDR_W / BYTE_W;
  localparam int HCNT_W = $clog2(HDR_BYTES);
  localparam logic [HCNT_W-1:0] HDR_LAST = HCNT_W'(HDR_BYTES - 1);
  localparam int IRQ_W = $clog2(IRQ_CYCLES + 1);

  xfer_state_t       state_q, state_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic              rd_q, rd_d, seen_q, seen_d;
  logic              req_q, req_d, wr_q, wr_d, wake_q, wake_d, irq_n_q;
  logic [LEN_W-1:0]  len_q, len_d, dcnt_q, dcnt_d;
  logic [ADDR_W-1:0] base_q, base_d, waddr_q, waddr_d, cur_addr;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [IRQ_W-1:0]  irq_cnt_q, irq_cnt_d;

  assign cur_addr = base_q + ADDR_W'(dcnt_q);

  always_comb begin
    state_d   = state_q;
    hcnt_d    = hcnt_q;
    rd_d      = rd_q;
    len_d     = len_q;
    base_d    = base_q;
    dcnt_d    = dcnt_q;
    seen_d    = seen_q;
    waddr_d   = waddr_q;
    wdata_d   = wdata_q;
    req_d     = 1'b0;
    wr_d      = 1'b0;
    wake_d    = 1'b0;
    irq_cnt_d = (irq_cnt_q != '0) ? irq_cnt_q - 1'b1 : irq_cnt_q;
    if (cs_start) begin
      state_d = ST_HDR;
      hcnt_d  = '0;
      dcnt_d  = '0;
      seen_d  = 1'b0;
    end else if (cs_end) begin
      wake_d  = !seen_q;
      if (state_q == ST_DONE) irq_cnt_d = IRQ_W'(IRQ_CYCLES);
      state_d = ST_HDR;
    end else begin
      if (sclk_rise) seen_d = 1'b1;
      if (byte_done) begin
        unique case (state_q)
          ST_HDR: begin
            if (hcnt_q == '0) begin
              rd_d  = rx_byte[BYTE_W-1];
              len_d = rx_byte[LEN_W-1:0];
            end else begin
              base_d = {base_q[ADDR_W-BYTE_W-1:0], rx_byte};
            end
            if (hcnt_q == HDR_LAST) begin
              req_d   = 1'b1;
              state_d = rdy ? ST_FLAG : ST_WAIT;
            end else begin
              hcnt_d = hcnt_q + 1'b1;
            end
          end
          ST_WAIT: state_d = rdy ? ST_FLAG : ST_WAIT;
          ST_FLAG: begin
            state_d = ST_DATA;
            dcnt_d  = '0;
          end
          ST_DATA: begin
            if (!rd_q) begin
              wr_d    = 1'b1;
              wdata_d = rx_byte;
              waddr_d = cur_addr;
            end
            if (dcnt_q == len_q) state_d = ST_DONE;
            else                 dcnt_d  = dcnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HDR;
      hcnt_q    <= '0;
      rd_q      <= 1'b0;
      len_q     <= '0;
      base_q    <= '0;
      dcnt_q    <= '0;
      seen_q    <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      req_q     <= 1'b0;
      wr_q      <= 1'b0;
      wake_q    <= 1'b0;
      irq_cnt_q <= '0;
      irq_n_q   <= 1'b1;
    end else begin
      state_q   <= state_d;
      hcnt_q    <= hcnt_d;
      rd_q      <= rd_d;
      len_q     <= len_d;
      base_q    <= base_d;
      dcnt_q    <= dcnt_d;
      seen_q    <= seen_d;
      waddr_q   <= waddr_d;
      wdata_q   <= wdata_d;
      req_q     <= req_d;
      wr_q      <= wr_d;
      wake_q    <= wake_d;
      irq_cnt_q <= irq_cnt_d;
      irq_n_q   <= (irq_cnt_d == '0);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_FLAG: tx_next = GO_CODE;
      ST_DATA: tx_next = rd_q ? bk_rdata : WAIT_CODE;
      default: tx_next = WAIT_CODE;
    endcase
  end

  assign bk_req      = req_q;
  assign bk_read     = rd_q;
  assign bk_len_m1   = len_q;
  assign bk_addr     = wr_q ? waddr_q : cur_addr;
  assign bk_wr_valid = wr_q;
  assign bk_wdata    = wdata_q;
  assign wake_pulse  = wake_q;
  assign irq_n       = irq_n_q;

  assert_flag_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLAG && $past(state_q) != ST_FLAG) |-> $past(rdy));
  assert_wr_only_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> ($past(state_q) == ST_DATA && !rd_q));
  assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_wake_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> !$fell(irq_n_q));
  if (IRQ_CYCLES > 1) begin : g_irq_chk
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_q) |=> !irq_n_q);
  end
endmodule

// File: rtl/spi_regtarget.sv
`timescale 1ns/1ps
module spi_regtarget
  import spi_regtarget_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W = 6,
  parameter int IRQ_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              bk_ready,
  input  logic [BYTE_W-1:0] bk_rdata,
  output logic              bk_req,
  output logic              bk_read,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [LEN_W-1:0]  bk_len_m1,
  output logic              bk_wr_valid,
  output logic [BYTE_W-1:0] bk_wdata,
  output logic              wake_pulse,
  output logic              irq_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // bit order: {ready, mosi, cs_n, sclk}; cs_n idles high
  logic [3:0] pins_s;
  spi_regtarget_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({bk_ready, spi_mosi, spi_cs_n, spi_sclk}),
    .dout (pins_s)
  );

  logic sclk_prev_q, cs_act_prev_q, cs_act;
  logic sclk_rise, sclk_fall, cs_start, cs_end;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_prev_q   <= 1'b0;
      cs_act_prev_q <= 1'b0;
    end else begin
      sclk_prev_q   <= pins_s[0];
      cs_act_prev_q <= cs_act;
    end
  end

  assign cs_act    = !pins_s[1];
  assign sclk_rise = cs_act &&  pins_s[0] && !sclk_prev_q;
  assign sclk_fall = cs_act && !pins_s[0] &&  sclk_prev_q;
  assign cs_start  = cs_act && !cs_act_prev_q;
  assign cs_end    = !cs_act && cs_act_prev_q;

  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_next;

  spi_regtarget_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_act   (cs_act),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .mosi     (pins_s[2]),
    .tx_next  (tx_next),
    .miso     (spi_miso),
    .byte_done(byte_done),
    .rx_byte  (rx_byte)
  );

  spi_regtarget_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IRQ_CYCLES(IRQ_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_start   (cs_start),
    .cs_end     (cs_end),
    .sclk_rise  (sclk_rise),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .rdy        (pins_s[3]),
    .bk_rdata   (bk_rdata),
    .tx_next    (tx_next),
    .bk_req     (bk_req),
    .bk_read    (bk_read),
    .bk_addr    (bk_addr),
    .bk_len_m1  (bk_len_m1),
    .bk_wr_valid(bk_wr_valid),
    .bk_wdata   (bk_wdata),
    .wake_pulse (wake_pulse),
    .irq_n      (irq_n)
  );

  assert_no_req_while_idle_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    bk_req |-> $past(cs_act));
endmodule

// File: tb/spi_regtarget_tb.sv
`timescale 1ns/1ps
module spi_regtarget_tb_top;
  localparam int IRQ_C = 5;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, ready = 1'b0;
  logic miso, bk_req, bk_read, bk_wr_valid, wake_pulse, irq_n;
  logic [23:0] bk_addr;
  logic [5:0]  bk_len_m1;
  logic [7:0]  bk_wdata, bk_rdata;

  int checks = 0, fails = 0;
  int req_cnt = 0, wr_cnt = 0, wake_cnt = 0;
  logic [23:0] req_addr, wr_addr_log [64];
  logic        req_rd;
  logic [5:0]  req_len;
  logic [7:0]  wr_data_log [64];
  logic [7:0]  wbuf [64];
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] model_rd(input logic [23:0] a);
    case (a)
      24'hD40F00: model_rd = 8'hE0;
      24'hD40F01: model_rd = 8'h1A;
      24'hD40F02: model_rd = 8'h28;
      24'hD40F03: model_rd = 8'h00;
      default:    model_rd = a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endcase
  endfunction

  assign bk_rdata = model_rd(bk_addr);

  spi_regtarget #(.IRQ_CYCLES(IRQ_C), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .bk_ready(ready), .bk_rdata(bk_rdata), .bk_req(bk_req),
    .bk_read(bk_read), .bk_addr(bk_addr), .bk_len_m1(bk_len_m1),
    .bk_wr_valid(bk_wr_valid), .bk_wdata(bk_wdata), .wake_pulse(wake_pulse), .irq_n(irq_n)
  );

  always @(negedge clk) begin
    if (bk_req) begin
      req_cnt++; req_addr = bk_addr; req_rd = bk_read; req_len = bk_len_m1;
    end
    if (bk_wr_valid) begin
      if (wr_cnt < 64) begin wr_addr_log[wr_cnt] = bk_addr; wr_data_log[wr_cnt] = bk_wdata; end
      wr_cnt++;
    end
    if (wake_pulse) wake_cnt++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1; rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic count_irq(output int lows);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (!irq_n) lows++;
    end
  endtask

  // full transaction; abort_after >= 0 raises CS after that many data bytes
  task automatic txn(input bit rd, input int len, input logic [23:0] addr,
                     input int w, input int abort_after);
    logic [7:0] rx, hdr [4];
    int zeros, k, bad, r0, w0, lows;
    bit flag, hdr_ok;
    hdr[0] = {rd, 1'b0, 6'(len - 1)};
    hdr[1] = addr[23:16]; hdr[2] = addr[15:8]; hdr[3] = addr[7:0];
    r0 = req_cnt; w0 = wr_cnt; hdr_ok = 1'b1;
    ready = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int h = 0; h < 4; h++) begin
      if (h == 3) ready = (w == 0);
      xfer(hdr[h], rx);
      if (rx != 8'h00) hdr_ok = 1'b0;
    end
    check(hdr_ok, "R2 header MISO zero", hdr_ok, 1);
    zeros = 0; flag = 1'b0; k = 4;
    while (!flag && k < 24) begin
      ready = (k >= 3 + w);
      xfer(8'h00, rx);
      if (rx == 8'h01) flag = 1'b1;
      else if (rx == 8'h00) zeros++;
      k++;
    end
    check(req_cnt == r0 + 1 && req_addr == addr && req_rd == rd && req_len == 6'(len - 1),
          "R1 request fields", {req_rd, req_len, req_addr}, {rd, 6'(len - 1), addr});
    check(zeros == w, "R3 wait byte count", zeros, w);
    check(flag, "R4 ready byte 0x01", flag, 1);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      if (abort_after >= 0 && i >= abort_after) break;
      xfer(rd ? 8'h00 : wbuf[i], rx);
      if (rd && rx != model_rd(addr + 24'(i))) begin
        bad++;
        $display("  R5 byte %0d got 0x%0h", i, rx);
      end
    end
    if (abort_after < 0) begin
      if (rd) check(bad == 0, "R5 read data", bad, 0);
      else begin
        bad = 0;
        for (int i = 0; i < len; i++)
          if (wr_addr_log[w0 + i] != addr + 24'(i) || wr_data_log[w0 + i] != wbuf[i]) bad++;
        check(wr_cnt == w0 + len && bad == 0, "R6 write pulses", wr_cnt - w0 + bad, len);
      end
      bad = 0;
      for (int e = 0; e < 2; e++) begin
        xfer(8'hFF, rx);
        if (rx != 8'h00) bad++;
      end
      repeat (4) @(negedge clk);
      check(bad == 0 && wr_cnt == w0 + (rd ? 0 : len), "R7 trailing bytes ignored",
            bad + wr_cnt - w0, rd ? 0 : len);
    end
    ready = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    count_irq(lows);
    if (abort_after < 0) check(lows == IRQ_C, "R8 irq pulse width", lows, IRQ_C);
    else                 check(lows == 0, "R9 no irq after abort", lows, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows, r0, wk0;
    logic [23:0] a;
    int lens [4] = '{1, 2, 5, 8};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(irq_n && !miso && !bk_req && !bk_wr_valid && !wake_pulse, "R11 reset state",
          {irq_n, miso, bk_req, bk_wr_valid, wake_pulse}, 5'b10000);

    // R10: chip-select toggle without clocks
    r0 = req_cnt; wk0 = wake_cnt;
    cs_n = 1'b0; repeat (20) @(negedge clk); cs_n = 1'b1;
    count_irq(lows);
    check(wake_cnt == wk0 + 1, "R10 wake pulse", wake_cnt - wk0, 1);
    check(lows == 0 && req_cnt == r0, "R10 no irq or request", lows + req_cnt - r0, 0);
    repeat (50) @(negedge clk);

    // R5: reference read of four bytes after three wait bytes
    txn(1'b1, 4, 24'hD40F00, 3, -1);
    wk0 = wake_cnt;

    // sweep direction x wait count x length
    for (int rd = 0; rd < 2; rd++)
      for (int w = 0; w < 4; w++)
        for (int li = 0; li < 4; li++) begin
          a = 24'h123400 + (24'(w) << 16) + (24'(rd) << 12) + ((lens[li] == 8) ? 24'hFC : 24'(lens[li]));
          for (int i = 0; i < 64; i++) wbuf[i] = 8'((i * 29 + w * 7 + lens[li]) & 8'hFF);
          txn(rd[0], lens[li], a, w, -1);
          repeat (10) @(negedge clk);
        end
    check(wake_cnt == wk0, "R10 no wake on clocked transactions", wake_cnt - wk0, 0);

    // R9: abort in data phase
    txn(1'b1, 4, 24'h000040, 1, 1);
    txn(1'b0, 3, 24'h000080, 0, 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule